// File: doc/BRIEF.md
# Memory-Mapped SPI Transmit Window

This block turns plain bus stores into SPI transmit traffic. Every chip select has its own write window, and an enable mask says which windows are live. The store's width sets how many bytes go out. A full-word store sends four bytes and a byte store sends one. The CPU never polls a data or status register. It issues stores, and the block stalls the bus through `wr_ready` until the previous store's bytes have left the shifter. Only one word is ever held.

The serial side runs in clock mode 0. SCK idles low, MOSI changes while SCK is low, and each byte goes out most significant bit first. Nothing is received. A software-visible configuration word decides what happens to chip select between stores. When the word is zero, chip select stays asserted from one store to the next, so a long stream looks like one framed transfer. When the word is non-zero, chip select is released after each store.

Top module: `spiwin_direct`

## Requirements
- R1: After reset `spi_cs_n` is all ones, `spi_sck` and `spi_mosi` are 0, `wr_ready` is 1, and the chip-select configuration word is zero (hold enabled).
- R2: A byte store (`wr_full`=0) to an enabled window sends `wr_data[7:0]` as 8 rising SCK edges, most significant bit first. MOSI is stable while SCK is high, and SCK idles low.
- R3: A full-word store (`wr_full`=1) sends four bytes in lane order: `wr_data[7:0]` first, then `[15:8]`, `[23:16]` and `[31:24]`.
- R4: Each SCK high or low phase lasts HALF clock cycles. A newly asserted chip select leads the first rising SCK edge by at least HALF cycles, and SCK toggles only while a chip select is asserted.
- R5: `wr_ready` falls in the cycle after a store to an enabled window is accepted. With hold enabled it stays low for 16·HALF cycles per byte sent.
- R6: A store whose `wr_cs` selects a disabled window (`win_en[wr_cs]`=0) is accepted with no effect: `wr_ready` stays 1, no SCK edge occurs and `spi_cs_n` does not change.
- R7: While the configuration word is zero, chip select stays asserted after a store finishes. Back-to-back stores to the same window produce no deassertion between them.
- R8: While the configuration word is non-zero, chip select deasserts HALF cycles after the final falling SCK edge, so `wr_ready` stays low for 16·HALF·bytes + HALF cycles. Writing a non-zero word while a chip select is held idle releases it.
- R9: At most one chip select is asserted at a time. A store to another window moves the assertion to the new chip select in one step.
- R10: `spi_cs_n` does not change while SCK is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_en | input | NUM_CS | Per-chip-select window enable mask |
| cfg_we | input | 1 | Write strobe for the chip-select configuration word |
| cfg_wdata | input | 32 | Configuration word; zero keeps chip select held between stores |
| wr_valid | input | 1 | Store into a window is presented |
| wr_ready | output | 1 | Store accepted when high together with `wr_valid` |
| wr_cs | input | $clog2(NUM_CS) | Window (chip select) addressed by the store |
| wr_full | input | 1 | 1 = full-word store (four bytes), 0 = byte store |
| wr_data | input | DATA_W | Store data; byte stores use bits 7:0 |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial transmit data |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The bound checker watches the serial-side invariants on every cycle. These are the one-hot chip select, SCK only under an asserted select, select and MOSI steady while SCK is high, the stall after an accepted store, and the absence of any reaction to a disabled window. Byte order, bit order, phase lengths, exact stall durations and the hold-versus-release behaviour of chip select across several stores can only be shown by the bench's scenarios. There a monitor rebuilds bytes from the serial lines and compares them with the stored data.

// File: rtl/spiwin_pkg.sv
package spiwin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2
    } eng_st_e;

endpackage

// File: rtl/spiwin_cfg.sv
module spiwin_cfg #(
    parameter int CFG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             keep_cs
);

    typedef struct packed {
        logic release_cs;
    } cfg_s;

    cfg_s cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.release_cs = |cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign keep_cs = !cfg_q.release_cs;

endmodule

// File: rtl/spiwin_halftimer.sv
module spiwin_halftimer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic expire
);

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        expire = run && (tmr_q.cnt == '0);
        if (restart || expire) begin
            tmr_d.cnt = RELOAD;
        end else if (run) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/spiwin_engine.sv
module spiwin_engine
    import spiwin_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      keep_cs,
    input  logic                      expire,
    input  logic [NUM_CS-1:0]         win_en,
    input  logic                      wr_valid,
    input  logic [$clog2(NUM_CS)-1:0] wr_cs,
    input  logic                      wr_full,
    input  logic [DATA_W-1:0]         wr_data,
    output logic                      wr_ready,
    output logic                      restart,
    output logic                      run,
    output logic                      sck,
    output logic                      mosi,
    output logic                      cs_act,
    output logic [$clog2(NUM_CS)-1:0] cs_idx
);

    localparam int BYTES = DATA_W / 8;
    localparam int LW    = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam int CSW   = $clog2(NUM_CS);

    typedef struct packed {
        eng_st_e          st;
        logic             sck;
        logic [2:0]       bitn;
        logic [LW-1:0]    left;
        logic [DATA_W-1:0] data;
        logic [7:0]       shreg;
        logic             cs_act;
        logic [CSW-1:0]   cs_idx;
    } eng_s;

    eng_s eng_d, eng_q;
    logic take;

    assign take = wr_valid && win_en[wr_cs];

    always_comb begin
        eng_d   = eng_q;
        restart = 1'b0;
        unique case (eng_q.st)
            ST_IDLE: begin
                if (take) begin
                    eng_d.st     = ST_SHIFT;
                    eng_d.sck    = 1'b0;
                    eng_d.bitn   = '0;
                    eng_d.data   = wr_data;
                    eng_d.shreg  = wr_data[7:0];
                    eng_d.left   = wr_full ? LW'(BYTES - 1) : '0;
                    eng_d.cs_act = 1'b1;
                    eng_d.cs_idx = wr_cs;
                    restart      = 1'b1;
                end else if (eng_q.cs_act && !keep_cs) begin
                    eng_d.cs_act = 1'b0;
                end
            end
            ST_SHIFT: begin
                if (expire) begin
                    if (!eng_q.sck) begin
                        eng_d.sck = 1'b1;
                    end else begin
                        eng_d.sck = 1'b0;
                        if (eng_q.bitn == 3'd7) begin
                            if (eng_q.left != '0) begin
                                eng_d.left  = eng_q.left - 1'b1;
                                eng_d.bitn  = '0;
                                eng_d.data  = eng_q.data >> 8;
                                eng_d.shreg = eng_q.data[15:8];
                            end else begin
                                eng_d.st = keep_cs ? ST_IDLE : ST_TAIL;
                            end
                        end else begin
                            eng_d.bitn  = eng_q.bitn + 1'b1;
                            eng_d.shreg = {eng_q.shreg[6:0], 1'b0};
                        end
                    end
                end
            end
            ST_TAIL: begin
                if (expire) begin
                    eng_d.cs_act = 1'b0;
                    eng_d.st     = ST_IDLE;
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: ST_IDLE, default: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign wr_ready = (eng_q.st == ST_IDLE);
    assign run      = (eng_q.st != ST_IDLE);
    assign sck      = eng_q.sck;
    assign mosi     = (eng_q.st == ST_SHIFT) ? eng_q.shreg[7] : 1'b0;
    assign cs_act   = eng_q.cs_act;
    assign cs_idx   = eng_q.cs_idx;

endmodule

// File: rtl/spiwin_direct.sv
module spiwin_direct #(
    parameter int NUM_CS = 8,
    parameter int DATA_W = 32,
    parameter int HALF   = 2,
    parameter int CFG_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CS-1:0]         win_en,
    input  logic                      cfg_we,
    input  logic [CFG_W-1:0]          cfg_wdata,
    input  logic                      wr_valid,
    output logic                      wr_ready,
    input  logic [$clog2(NUM_CS)-1:0] wr_cs,
    input  logic                      wr_full,
    input  logic [DATA_W-1:0]         wr_data,
    output logic                      spi_sck,
    output logic                      spi_mosi,
    output logic [NUM_CS-1:0]         spi_cs_n
);

    localparam int CSW = $clog2(NUM_CS);

    logic           keep_cs;
    logic           restart;
    logic           run;
    logic           expire;
    logic           cs_act;
    logic [CSW-1:0] cs_idx;

    spiwin_cfg #(.CFG_W(CFG_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .keep_cs   (keep_cs)
    );

    spiwin_halftimer #(.HALF(HALF)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run     (run),
        .expire  (expire)
    );

    spiwin_engine #(.NUM_CS(NUM_CS), .DATA_W(DATA_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .keep_cs  (keep_cs),
        .expire   (expire),
        .win_en   (win_en),
        .wr_valid (wr_valid),
        .wr_cs    (wr_cs),
        .wr_full  (wr_full),
        .wr_data  (wr_data),
        .wr_ready (wr_ready),
        .restart  (restart),
        .run      (run),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .cs_act   (cs_act),
        .cs_idx   (cs_idx)
    );

    for (genvar g = 0; g < NUM_CS; g++) begin : g_csn
        assign spi_cs_n[g] = !(cs_act && (cs_idx == CSW'(g)));
    end

endmodule

// File: rtl/spiwin_direct_chk.sv
module spiwin_direct_chk #(
    parameter int NUM_CS = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_CS-1:0]         win_en,
    input logic                      wr_valid,
    input logic                      wr_ready,
    input logic [$clog2(NUM_CS)-1:0] wr_cs,
    input logic                      spi_sck,
    input logic                      spi_mosi,
    input logic [NUM_CS-1:0]         spi_cs_n
);

    // R9: one select at most
    p_one_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n));

    // R4: SCK moves only under an asserted select
    p_sck_needs_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> (~spi_cs_n != '0));

    // R10: select steady while SCK high
    p_cs_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> $stable(spi_cs_n));

    // R2: MOSI steady across the high phase
    p_mosi_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    // R5: stall follows an accepted store
    p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && win_en[wr_cs]) |=> !wr_ready);

    // R6: disabled window leaves everything untouched
    p_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && !win_en[wr_cs]) |=> (wr_ready && $stable(spi_cs_n) && !spi_sck));

    // R1: SCK idles low whenever the block is ready
    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !spi_sck);

endmodule

bind spiwin_direct spiwin_direct_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_en   (win_en),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_cs    (wr_cs),
    .spi_sck  (spi_sck),
    .spi_mosi (spi_mosi),
    .spi_cs_n (spi_cs_n)
);

// File: tb/tb_spiwin_direct.sv
module tb_spiwin_direct;

    localparam int PERIOD = 10;
    localparam int NCS    = 8;
    localparam int HALF   = 2;
    localparam int CSW    = $clog2(NCS);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCS-1:0]  win_en = 8'b1101_1111;
    logic            cfg_we = 1'b0;
    logic [31:0]     cfg_wdata = '0;
    logic            wr_valid = 1'b0;
    logic            wr_ready;
    logic [CSW-1:0]  wr_cs = '0;
    logic            wr_full = 1'b0;
    logic [31:0]     wr_data = '0;
    logic            spi_sck;
    logic            spi_mosi;
    logic [NCS-1:0]  spi_cs_n;

    int checks = 0;
    int errors = 0;
    int cycle  = 0;

    // bus-side monitor state
    logic [7:0]     cap_byte [0:63];
    int             cap_cs   [0:63];
    int             n_cap = 0;
    int             n_rise = 0;
    int             n_deassert = 0;
    logic [7:0]     acc = '0;
    int             nbits = 0;
    logic           sck_prev = 1'b0;
    logic [NCS-1:0] csn_prev = '1;
    int             assert_cyc = 0;
    logic           gap_pending = 1'b0;

    spiwin_direct #(.NUM_CS(NCS), .DATA_W(32), .HALF(HALF), .CFG_W(32)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_en    (win_en),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .wr_cs     (wr_cs),
        .wr_full   (wr_full),
        .wr_data   (wr_data),
        .spi_sck   (spi_sck),
        .spi_mosi  (spi_mosi),
        .spi_cs_n  (spi_cs_n)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycle++;
        if (rst_n) begin
            for (int i = 0; i < NCS; i++) begin
                if (!csn_prev[i] && spi_cs_n[i]) n_deassert++;
            end
            if ((csn_prev & ~spi_cs_n) != '0) begin
                assert_cyc  = cycle;
                gap_pending = 1'b1;
            end
            if (spi_sck && !sck_prev) begin
                n_rise++;
                if (gap_pending) begin
                    check((cycle - assert_cyc) >= HALF, "R4 cs setup", cycle - assert_cyc, HALF);
                    gap_pending = 1'b0;
                end
                acc = {acc[6:0], spi_mosi};
                nbits++;
                if (nbits == 8) begin
                    cap_byte[n_cap] = acc;
                    cap_cs[n_cap]   = -1;
                    for (int i = 0; i < NCS; i++) begin
                        if (!spi_cs_n[i]) cap_cs[n_cap] = i;
                    end
                    if (n_cap < 63) n_cap++;
                    nbits = 0;
                end
            end
            sck_prev = spi_sck;
            csn_prev = spi_cs_n;
        end
    end

    task automatic store(input int cs, input logic full, input logic [31:0] d);
        @(negedge clk);
        wr_cs = CSW'(cs); wr_full = full; wr_data = d; wr_valid = 1'b1;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (!wr_ready) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic set_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check(spi_cs_n == '1, "R1 cs_n", spi_cs_n, '1);
        check(!spi_sck && !spi_mosi, "R1 sck/mosi", {spi_sck, spi_mosi}, 0);
        check(wr_ready, "R1 ready", wr_ready, 1);
    endtask

    task automatic t_byte;
        int n0, len;
        n0 = n_cap;
        store(2, 1'b0, 32'hFFFF_FFA5);
        busy_len(len);
        check(len == 16*HALF, "R5 byte stall", len, 16*HALF);
        check(n_cap == n0 + 1, "R2 byte count", n_cap - n0, 1);
        check(cap_byte[n0] == 8'hA5, "R2 byte value", cap_byte[n0], 8'hA5);
        check(cap_cs[n0] == 2, "R2 byte cs", cap_cs[n0], 2);
        check(spi_cs_n == ~8'h04, "R7 held after byte", spi_cs_n, ~8'h04);
    endtask

    task automatic t_word;
        int n0, d0, len;
        logic [7:0] exp [0:3];
        exp[0] = 8'h44; exp[1] = 8'h33; exp[2] = 8'h22; exp[3] = 8'h11;
        n0 = n_cap; d0 = n_deassert;
        store(2, 1'b1, 32'h1122_3344);
        busy_len(len);
        check(len == 64*HALF, "R5 word stall", len, 64*HALF);
        check(n_cap == n0 + 4, "R3 word count", n_cap - n0, 4);
        for (int i = 0; i < 4; i++) begin
            check(cap_byte[n0+i] == exp[i], "R3 lane order", cap_byte[n0+i], exp[i]);
        end
        check(n_deassert == d0, "R7 no release", n_deassert - d0, 0);
    endtask

    task automatic t_disabled;
        int r0, n0;
        logic [NCS-1:0] c0;
        r0 = n_rise; n0 = n_cap; c0 = spi_cs_n;
        store(5, 1'b1, 32'hDEAD_BEEF);
        check(wr_ready, "R6 ready kept", wr_ready, 1);
        repeat (20*HALF) @(negedge clk);
        check(n_rise == r0 && n_cap == n0, "R6 no sck", n_rise - r0, 0);
        check(spi_cs_n == c0, "R6 cs unchanged", spi_cs_n, c0);
    endtask

    task automatic t_switch;
        int n0, len;
        n0 = n_cap;
        store(1, 1'b0, 32'h0000_003C);
        busy_len(len);
        check(cap_byte[n0] == 8'h3C && cap_cs[n0] == 1, "R9 new cs byte", {cap_cs[n0][7:0], cap_byte[n0]}, 16'h013C);
        check(spi_cs_n == ~8'h02, "R9 moved select", spi_cs_n, ~8'h02);
    endtask

    task automatic t_release;
        int n0, len, d0;
        set_cfg(32'h1);
        check(spi_cs_n == '1, "R8 idle release", spi_cs_n, '1);
        n0 = n_cap;
        store(3, 1'b0, 32'h0000_0081);
        busy_len(len);
        check(len == 17*HALF, "R8 stall with tail", len, 17*HALF);
        check(spi_cs_n == '1, "R8 released", spi_cs_n, '1);
        check(cap_byte[n0] == 8'h81 && cap_cs[n0] == 3, "R8 byte", cap_byte[n0], 8'h81);
        set_cfg(32'h0);
        store(4, 1'b0, 32'h0000_0012);
        busy_len(len);
        d0 = n_deassert; n0 = n_cap;
        store(4, 1'b0, 32'h0000_00E7);
        busy_len(len);
        check(n_deassert == d0, "R7 back to back", n_deassert - d0, 0);
        check(cap_byte[n0] == 8'hE7 && cap_cs[n0] == 4, "R7 second byte", cap_byte[n0], 8'hE7);
        check(spi_cs_n == ~8'h10, "R7 held", spi_cs_n, ~8'h10);
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_byte();
        t_word();
        t_disabled();
        t_switch();
        t_release();
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule